// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static RAM Sequencer

This block sits between a synchronous on-chip master and an external asynchronous static RAM of 64K words by 16 bits. The RAM has one active-low select per byte lane. The host presents one request at a time with a valid flag, a write flag, a word address, write data and a per-lane byte enable. The block accepts the request while its ready output is high and then runs a fixed, cycle-counted sequence on the memory pins. A read ends with a one-cycle read-valid pulse carrying the sampled word. A write ends silently.

Every memory timing rule is enforced with clock-cycle counts given as parameters. These are the address-to-data delay, the write-enable low width, the data setup before the write ends and the minimum cycle time. The defaults suit a 10 ns clock. The address and lane selects only move while write enable is high. Output enable never falls during a write, so the memory never has its drivers on while the block drives the bus. The data bus is split into an outgoing word, an incoming word and a drive-enable. Pad tri-states belong outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and straight after reset, `req_ready` is 1 and `rd_valid` is 0. `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, every bit of `mem_bs_n` is 1, and `mem_dq_oe` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. For a read, that edge drives `mem_addr` to the request address and `mem_bs_n` to the inverse of `req_be` (bit 0 selects data bits 7:0, bit 1 selects bits 15:8). It also sets `mem_ce_n` and `mem_oe_n` to 0 and leaves `mem_we_n` at 1.
- R3: A read samples `mem_dq_in` on the edge exactly T_RD cycles after the accept edge. That same edge raises `rd_valid` for one cycle. Lane i of `rd_data` holds the sampled lane if `req_be[i]` was 1 and zero otherwise.
- R4: For a write, the accept edge drives the address, `mem_ce_n`=0 and `mem_bs_n`=~`req_be` with `mem_we_n` still 1. `mem_we_n` falls one edge later and stays low for exactly max(T_WP, T_DS+1) cycles. `mem_oe_n` stays 1 throughout.
- R5: `mem_dq_oe` rises one cycle after `mem_we_n` falls and falls on the same edge that `mem_we_n` rises. `mem_dq_out` holds the request data while driven, so data is driven at least T_DS cycles before the end of the write. `mem_dq_oe` is never 1 while `mem_we_n` is 1.
- R6: `mem_addr` changes only on an edge where `mem_we_n` is 1 both before and after.
- R7: `req_ready` is 0 from the accept edge until the access has ended and at least T_CYC cycles have passed since that edge. With back-to-back requests, accept edges are max(T_CYC, end+1) cycles apart, where end is T_RD for a read and max(T_WP, T_DS+1)+1 for a write.
- R8: The edge that ends an access returns `mem_ce_n`, `mem_oe_n`, `mem_we_n` and all of `mem_bs_n` to 1. While `mem_ce_n` is 1, `mem_dq_oe` is 0.
- R9: A request with `req_be`=0 keeps every `mem_bs_n` bit at 1 for the whole access. Such a write leaves the memory contents unchanged, and such a read returns `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_ready | output | 1 | Request can be accepted this cycle |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 16 | Read word, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_bs_n | output | 2 | Lane selects, active low, bit 0 = bits 7:0 |
| mem_addr | output | 16 | Memory word address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
A wrong sequencer state or count shows up at the pins within one access. It appears as a read-valid pulse one cycle early or late, or as a write pulse of the wrong width measured on the write-enable pin. It can also appear as a drive-enable that overlaps a high write enable. The bench's memory model returns a junk pattern until the address has been held for T_RD cycles. An early sample therefore yields a wrong word on the very next read-valid pulse, and a lost lane select shows up on the next read of that address. A spacing error between accesses appears as a wrong accept-to-accept distance on the following request.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_READ   = 2'd1,
      SEQ_WSETUP = 2'd2,
      SEQ_WPULSE = 2'd3
   } seq_state_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int unsigned LIMIT = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] elapsed
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (LIMIT >= (1 << CNT_W)) begin : g_bad_width
      $error("timer width too small for limit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         elapsed <= LIM;
      else if (restart)
         elapsed <= ONE;
      else if (elapsed < LIM)
         elapsed <= elapsed + ONE;
   end

   // R7
   timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elapsed <= LIM);

   // R7
   timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> elapsed == ONE);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int unsigned T_RD  = 6,
   parameter int unsigned T_WP  = 5,
   parameter int unsigned T_DS  = 3,
   parameter int unsigned T_CYC = 6,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [CNT_W-1:0] elapsed,
   output logic             ready,
   output logic             accept,
   output logic             sample,
   output logic             finish,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);
   localparam int unsigned W_LOW = max_u(T_WP, T_DS + 1);
   localparam logic [CNT_W-1:0] RD_AT   = CNT_W'(T_RD);
   localparam logic [CNT_W-1:0] WEND_AT = CNT_W'(W_LOW + 1);
   localparam logic [CNT_W-1:0] CYC_AT  = CNT_W'(T_CYC);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   seq_state_e state;
   logic       wr_end;
   logic [CNT_W-1:0] wl_cnt;

   always_comb begin
      ready  = (state == SEQ_IDLE) && (elapsed >= CYC_AT);
      accept = req_valid && ready;
      sample = (state == SEQ_READ) && (elapsed == RD_AT);
      wr_end = (state == SEQ_WPULSE) && (elapsed == WEND_AT);
      finish = sample || wr_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         ce_n  <= 1'b1;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  ce_n <= 1'b0;
                  if (req_write) begin
                     state <= SEQ_WSETUP;
                  end else begin
                     oe_n  <= 1'b0;
                     state <= SEQ_READ;
                  end
               end
            end
            SEQ_READ: begin
               if (sample) begin
                  ce_n  <= 1'b1;
                  oe_n  <= 1'b1;
                  state <= SEQ_IDLE;
               end
            end
            SEQ_WSETUP: begin
               we_n  <= 1'b0;
               state <= SEQ_WPULSE;
            end
            SEQ_WPULSE: begin
               if (wr_end) begin
                  we_n  <= 1'b1;
                  dq_oe <= 1'b0;
                  ce_n  <= 1'b1;
                  state <= SEQ_IDLE;
               end else begin
                  dq_oe <= 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // low-width counter kept only for the pulse-width property
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wl_cnt <= '0;
      else if (we_n)
         wl_cnt <= '0;
      else if (wl_cnt != '1)
         wl_cnt <= wl_cnt + ONE;
   end

   // R4
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (wl_cnt == CNT_W'(W_LOW)) && (wl_cnt >= CNT_W'(T_WP)));

   // R4
   oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n);

   // R5
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !we_n);

   // R5
   drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !dq_oe);

   // R7
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |-> !ready);

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              finish,
   input  logic              sample,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_bs_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned LANE_W = DATA_W / LANES;

   logic [LANES-1:0] be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         be_q       <= '0;
         rd_valid   <= 1'b0;
      end else begin
         rd_valid <= sample;
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            be_q       <= req_be;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic              sel_n_q;
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_n_q <= 1'b1;
         else if (accept)
            sel_n_q <= ~req_be[i];
         else if (finish)
            sel_n_q <= 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else if (sample)
            rd_q <= be_q[i] ? mem_dq_in[i*LANE_W +: LANE_W] : '0;
      end

      assign mem_bs_n[i]               = sel_n_q;
      assign rd_data[i*LANE_W +: LANE_W] = rd_q;
   end

   // R3
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R9
   lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (be_q == '0) && !accept |-> &mem_bs_n);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned T_RD   = 6,
   parameter int unsigned T_WP   = 5,
   parameter int unsigned T_DS   = 3,
   parameter int unsigned T_CYC  = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W/8-1:0]    req_be,
   output logic                   req_ready,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   mem_ce_n,
   output logic                   mem_we_n,
   output logic                   mem_oe_n,
   output logic [DATA_W/8-1:0]    mem_bs_n,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_dq_out,
   input  logic [DATA_W-1:0]      mem_dq_in,
   output logic                   mem_dq_oe
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned W_LOW = max_u(T_WP, T_DS + 1);
   localparam int unsigned SAT   = max_u(T_CYC, max_u(T_RD, W_LOW + 1));
   localparam int unsigned CNT_W = $clog2(SAT + 1);

   if ((DATA_W % 8) != 0 || DATA_W == 0) begin : g_bad_data
      $error("data width must be a whole number of bytes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("address width must be positive");
   end
   if (T_RD < 1 || T_WP < 1 || T_DS < 1 || T_CYC < 1) begin : g_bad_timing
      $error("every timing count must be at least one cycle");
   end

   logic             accept;
   logic             sample;
   logic             finish;
   logic [CNT_W-1:0] elapsed;

   sram_lane_timer #(
      .LIMIT (SAT),
      .CNT_W (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .elapsed (elapsed)
   );

   sram_lane_seq #(
      .T_RD  (T_RD),
      .T_WP  (T_WP),
      .T_DS  (T_DS),
      .T_CYC (T_CYC),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .elapsed   (elapsed),
      .ready     (req_ready),
      .accept    (accept),
      .sample    (sample),
      .finish    (finish),
      .ce_n      (mem_ce_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_lane_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .finish     (finish),
      .sample     (sample),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_be     (req_be),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_bs_n   (mem_bs_n),
      .mem_dq_out (mem_dq_out),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

   // R6
   addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> mem_we_n && $past(mem_we_n));

   // R8
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> !mem_dq_oe && (&mem_bs_n) && mem_we_n && mem_oe_n);

   // R2
   read_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n && mem_we_n);

   // R5
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe && $past(mem_dq_oe) |-> $stable(mem_dq_out));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
   localparam int TRD  = 4;
   localparam int TWP  = 3;
   localparam int TDS  = 3;
   localparam int TCYC = 7;
   localparam int WLOW = (TWP > TDS + 1) ? TWP : TDS + 1;
   localparam int WR_END = WLOW + 1;
   localparam int RD_END = TRD;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_ready, rd_valid;
   logic [15:0] req_addr, req_wdata, rd_data;
   logic [1:0]  req_be, mem_bs_n;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [15:0] mem_addr, mem_dq_out;
   logic [15:0] mem_dq_in = 16'hBAD0;

   always #4 clk = ~clk;

   sram_lane_ctrl #(
      .ADDR_W(16), .DATA_W(16), .T_RD(TRD), .T_WP(TWP), .T_DS(TDS), .T_CYC(TCYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [15:0] exp_mem  [logic [15:0]];
   logic [15:0] sram_mem [logic [15:0]];
   logic [15:0] exp_q [$];
   int          acc_q [$];
   string       tag_q [$];
   int          last_acc = -1;
   int          last_end = 0;
   bit          tight = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [15:0] pat(input logic [15:0] a);
      return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C};
   endfunction

   function automatic logic [15:0] lmask(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [15:0] exp_get(input logic [15:0] a);
      return exp_mem.exists(a) ? exp_mem[a] : pat(a);
   endfunction

   function automatic logic [15:0] sram_get(input logic [15:0] a);
      return sram_mem.exists(a) ? sram_mem[a] : pat(a);
   endfunction

   // driver: issue one request, check the accept edge, push expectations
   task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input string tag);
      int acc;
      logic [15:0] m;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      acc = cyc;
      chk(req_ready == 1'b0, "R7 ready low after accept", {31'd0, req_ready}, 32'd0);
      if (last_acc >= 0) begin
         if (tight)
            chk(acc - last_acc == ((TCYC > last_end + 1) ? TCYC : last_end + 1),
                "R7 back-to-back spacing", acc - last_acc,
                (TCYC > last_end + 1) ? TCYC : last_end + 1);
         else
            chk(acc - last_acc >= TCYC, "R7 minimum spacing", acc - last_acc, TCYC);
      end
      if (w) begin
         // R4 write setup cycle: select and address, write enable still high
         chk({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_addr} == {1'b0, 1'b1, 1'b1, ~be, a},
             {"R4 write accept pins ", tag},
             {13'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_addr},
             {13'd0, 1'b0, 1'b1, 1'b1, ~be, a});
         m = lmask(be);
         exp_mem[a] = (exp_get(a) & ~m) | (d & m);
      end else begin
         // R2 read accept pins
         chk({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_addr} == {1'b0, 1'b1, 1'b0, ~be, a},
             {"R2 read accept pins ", tag},
             {13'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_addr},
             {13'd0, 1'b0, 1'b1, 1'b0, ~be, a});
         exp_q.push_back(exp_get(a) & lmask(be));
         acc_q.push_back(acc);
         tag_q.push_back(tag);
      end
      last_acc = acc;
      last_end = w ? WR_END : RD_END;
      tight = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      tight = 1'b0;
   endtask

   // monitor: scoreboard for read completions
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected rd_valid", 32'd1, 32'd0);
         end else begin
            logic [15:0] e;
            int          a;
            string       t;
            e = exp_q.pop_front();
            a = acc_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data == e, {t, " read data"}, {16'd0, rd_data}, {16'd0, e});
            chk(cyc - a == TRD, "R3 read latency", cyc - a, TRD);
            chk({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n} == 5'b11111, "R8 read release",
                {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, 32'h1F);
         end
      end
   end

   // memory model and pin protocol monitor
   int          wl = 0, dl = 0, rd_age = 0;
   bit          oe_bad = 1'b0, prev_we = 1'b1;
   logic [15:0] prev_addr = 16'h0, w_data = 16'h0, w_adr = 16'h0, rd_adr = 16'h0;
   logic [1:0]  w_bs = 2'b11;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_we_n) begin
            wl++;
            if (!mem_oe_n) oe_bad = 1'b1;
            if (mem_dq_oe) begin
               dl++;
               w_data = mem_dq_out;
            end
            w_bs  = mem_bs_n;
            w_adr = mem_addr;
         end else if (!prev_we) begin
            chk(wl == WLOW, "R4 write pulse width", wl, WLOW);
            chk(!oe_bad, "R4 output enable high during write", {31'd0, oe_bad}, 32'd0);
            chk(dl == WLOW - 1 && dl >= TDS, "R5 data drive window", dl, WLOW - 1);
            chk(!mem_dq_oe, "R5 release with write enable", {31'd0, mem_dq_oe}, 32'd0);
            chk(mem_ce_n && (&mem_bs_n), "R8 write release",
                {29'd0, mem_ce_n, mem_bs_n}, 32'h7);
            if (!w_bs[0]) sram_mem[w_adr] = {sram_get(w_adr)[15:8], w_data[7:0]};
            if (!w_bs[1]) sram_mem[w_adr] = {w_data[15:8], sram_get(w_adr)[7:0]};
            wl = 0; dl = 0; oe_bad = 1'b0;
         end
         if (mem_dq_oe && mem_we_n)
            chk(1'b0, "R5 drive while write enable high", 32'd1, 32'd0);
         if (mem_addr != prev_addr)
            chk(mem_we_n && prev_we, "R6 address moved with write enable low",
                {30'd0, prev_we, mem_we_n}, 32'd3);
         if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (rd_age == 0 || mem_addr != rd_adr) begin
               rd_adr = mem_addr;
               rd_age = 1;
            end else begin
               rd_age++;
            end
         end else begin
            rd_age = 0;
         end
         if (rd_age >= TRD)
            mem_dq_in = {mem_bs_n[1] ? 8'hEE : sram_get(rd_adr)[15:8],
                         mem_bs_n[0] ? 8'hEE : sram_get(rd_adr)[7:0]};
         else
            mem_dq_in = 16'hBAD0;
         prev_we   = mem_we_n;
         prev_addr = mem_addr;
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "R7 watchdog expired", cyc, 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_be = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe} == 8'b10111110,
          "R1 pins in reset", {24'd0, req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe},
          32'hBE);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe} == 8'b10111110,
          "R1 pins after reset", {24'd0, req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe},
          32'hBE);

      issue(1'b0, 16'h0010, 16'h0, 2'b11, "R3");
      idle(3);
      issue(1'b1, 16'h0010, 16'h1234, 2'b11, "R4");
      issue(1'b0, 16'h0010, 16'h0, 2'b11, "R3");
      issue(1'b1, 16'h0020, 16'h77AA, 2'b01, "R5");
      issue(1'b0, 16'h0020, 16'h0, 2'b11, "R3 lower lane write");
      issue(1'b1, 16'h0020, 16'h5566, 2'b10, "R5");
      issue(1'b0, 16'h0020, 16'h0, 2'b11, "R3 upper lane write");
      issue(1'b0, 16'h0020, 16'h0, 2'b01, "R3 lower lane mask");
      issue(1'b0, 16'h0020, 16'h0, 2'b10, "R3 upper lane mask");
      idle(5);
      // R9 empty byte enables
      issue(1'b1, 16'h0010, 16'hFFFF, 2'b00, "R9");
      issue(1'b0, 16'h0010, 16'h0, 2'b11, "R9 write without lanes");
      issue(1'b0, 16'h0010, 16'h0, 2'b00, "R9 read without lanes");
      idle(2);
      // address extremes
      issue(1'b1, 16'hFFFF, 16'hC0DE, 2'b11, "R6");
      issue(1'b1, 16'h0000, 16'hBEEF, 2'b11, "R6");
      issue(1'b0, 16'hFFFF, 16'h0, 2'b11, "R3 top address");
      issue(1'b0, 16'h0000, 16'h0, 2'b11, "R3 bottom address");
      idle(4);
      // back-to-back burst with varied lanes
      for (int i = 0; i < 8; i++)
         issue(1'b1, 16'(i * 16'h1111), 16'(16'h0F0F ^ (i * 16'h0123)), 2'(i % 4), "R7");
      for (int i = 0; i < 8; i++)
         issue(1'b0, 16'(i * 16'h1111), 16'h0, 2'b11, "R7 burst readback");
      idle(12);
      chk(exp_q.size() == 0, "R3 reads left unanswered", exp_q.size(), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule